// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host side of a three-wire serial link to a delta-sigma converter whose chip select is tied low for good. With no select line to mark a frame, the converter's data-out line does double duty. Between frames it reads high while a conversion runs. It drops low once a result is latched and ready. The reader watches that level while its serial clock rests low. When the level drops, it runs one frame of exactly 32 clock pulses. During the frame it captures the result from the converter and sends a configuration word to it. It then presents the captured word on a parallel port with a one-cycle strobe.

The serial clock comes from the system clock through a programmable half-period divider. The configuration word is built from separate field inputs. A programmable poll limit reports a converter that never becomes ready. The state machine has five states:
- `S_IDLE`: waiting for a request.
- `S_POLL`: clock low, watching the ready level.
- `S_LOW`: low half of a clock pulse.
- `S_HIGH`: high half of a clock pulse.
- `S_DONE`: a one-cycle result strobe.

The transitions are:
- `S_IDLE`→`S_POLL` on an accepted request.
- `S_POLL`→`S_LOW` when the line is seen low on a divider tick.
- `S_POLL`→`S_IDLE` when the poll limit expires.
- `S_LOW`→`S_HIGH` on a tick, which is the rising edge.
- `S_HIGH`→`S_LOW` on a tick, which is the falling edge.
- `S_HIGH`→`S_DONE` on the 32nd falling edge.
- `S_DONE`→`S_IDLE` on the next cycle.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `sck`, `mosi`, `busy`, `result_valid` and `timeout_err` are all low.
- R2: A `start` pulse in idle begins polling. While polling, `sck` stays low and `miso` is sampled once per divider tick. A frame begins only after a tick sees `miso` low.
- R3: A frame has exactly 32 `sck` pulses. Each high and each low phase lasts `half_div` system clocks, and a `half_div` of 0 acts as 1.
- R4: `miso` is sampled at each rising `sck` edge. The first bit sampled lands in `result[31]` and the last in `result[0]`.
- R5: `mosi` changes only while `sck` is low, so it is stable through every high phase.
- R6: The outgoing word is sent MSB first, one bit per pulse. Bit 31 is 1 and bit 30 is 0. The remaining fields are: bit 29 `cfg_en`, bit 28 `cfg_sgl`, bit 27 `cfg_odd`, bits 26:24 `cfg_addr`, bit 23 `cfg_en2`, bit 22 `cfg_temp`, bit 21 `cfg_rej_a`, bit 20 `cfg_rej_b`, bit 19 `cfg_spd`. Bits 18:0 are 0.
- R7: After the 32nd falling edge, `result_valid` is high for exactly one cycle with the captured word on `result`, and `busy` then falls.
- R8: With a nonzero `tmo_limit`, that many consecutive poll ticks with `miso` high set `timeout_err` and return to idle with no `sck` pulse. A `tmo_limit` of 0 never times out. An accepted `start` clears `timeout_err`.
- R9: `start` is ignored while `busy` is high, so no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to read one result |
| cfg_en | input | 1 | Channel-field enable bit |
| cfg_sgl | input | 1 | Single-ended / differential select |
| cfg_odd | input | 1 | Odd / sign select |
| cfg_addr | input | 3 | Channel address |
| cfg_en2 | input | 1 | Second-group enable bit |
| cfg_temp | input | 1 | Temperature-sensor select |
| cfg_rej_a | input | 1 | Rejection-frequency select, first bit |
| cfg_rej_b | input | 1 | Rejection-frequency select, second bit |
| cfg_spd | input | 1 | Speed select |
| half_div | input | 8 | System clocks per half serial-clock period |
| tmo_limit | input | 16 | Poll ticks before timeout, 0 disables |
| miso | input | 1 | Converter data-out, also the ready flag |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Configuration data to the converter |
| busy | output | 1 | High from accepted request until return to idle |
| result | output | 32 | Captured conversion word |
| result_valid | output | 1 | One-cycle strobe for `result` |
| timeout_err | output | 1 | Poll limit expired |

## Verification
The assertions assume a converter that changes `miso` only after a falling `sck` edge or while the clock rests low. They also assume that `half_div`, `tmo_limit` and the configuration fields stay steady while `busy` is high. The stimulus model drives `miso` only from falling serial-clock edges or from the clock's falling system edge during polling. It randomizes divider settings, ready delays, data and fields, but only between frames. Directed cases cover a divider of 0, timeout expiry, a disabled limit and a request made mid-frame.

// File: rtl/afr_pkg.sv
package afr_pkg;
    localparam int FRAME_BITS = 32;
    localparam int PAD_BITS   = 19;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL,
        S_LOW,
        S_HIGH,
        S_DONE
    } afr_state_t;

    typedef struct packed {
        logic       en;
        logic       sgl;
        logic       odd;
        logic [2:0] addr;
        logic       en2;
        logic       temp;
        logic       rej_a;
        logic       rej_b;
        logic       spd;
    } afr_cfg_t;

    function automatic logic [FRAME_BITS-1:0] afr_word(input afr_cfg_t c);
        return {2'b10, c, {PAD_BITS{1'b0}}};
    endfunction
endpackage

// File: rtl/afr_pacer.sv
module afr_pacer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim  = (half_div == '0) ? '0 : half_div - 1'b1;
    assign tick = run && (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/afr_shifter.sv
module afr_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], ser_in};
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import afr_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  cfg_en,
    input  logic                  cfg_sgl,
    input  logic                  cfg_odd,
    input  logic [2:0]            cfg_addr,
    input  logic                  cfg_en2,
    input  logic                  cfg_temp,
    input  logic                  cfg_rej_a,
    input  logic                  cfg_rej_b,
    input  logic                  cfg_spd,
    input  logic [DIV_W-1:0]      half_div,
    input  logic [TMO_W-1:0]      tmo_limit,
    input  logic                  miso,
    output logic                  sck,
    output logic                  mosi,
    output logic                  busy,
    output logic [FRAME_BITS-1:0] result,
    output logic                  result_valid,
    output logic                  timeout_err
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    afr_state_t       state, nxt;
    logic             tick;
    logic [CNT_W-1:0] bit_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             tmo_hit;
    logic             last_bit;
    logic             accept;
    logic             rise_ev, fall_ev;
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    afr_cfg_t         cfg;

    assign cfg      = '{en: cfg_en, sgl: cfg_sgl, odd: cfg_odd, addr: cfg_addr,
                        en2: cfg_en2, temp: cfg_temp, rej_a: cfg_rej_a,
                        rej_b: cfg_rej_b, spd: cfg_spd};
    assign accept   = (state == S_IDLE) && start;
    assign tmo_hit  = (tmo_limit != '0) && (tmo_cnt == tmo_limit - 1'b1);
    assign last_bit = (bit_cnt == CNT_W'(FRAME_BITS - 1));
    assign rise_ev  = (state == S_LOW) && tick;
    assign fall_ev  = (state == S_HIGH) && tick;

    afr_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state != S_IDLE && state != S_DONE),
        .half_div (half_div),
        .tick     (tick)
    );

    afr_shifter #(.W(FRAME_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (afr_word(cfg)),
        .shift    (fall_ev),
        .ser_in   (1'b0),
        .q        (tx_q)
    );

    afr_shifter #(.W(FRAME_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ('0),
        .shift    (rise_ev),
        .ser_in   (miso),
        .q        (rx_q)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_POLL;
            S_POLL: if (tick) begin
                        if (!miso)        nxt = S_LOW;
                        else if (tmo_hit) nxt = S_IDLE;
                    end
            S_LOW:  if (tick) nxt = S_HIGH;
            S_HIGH: if (tick) nxt = last_bit ? S_DONE : S_LOW;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
            tmo_cnt <= '0;
        end else begin
            state <= nxt;
            if (accept)
                tmo_cnt <= '0;
            else if (state == S_POLL && tick && miso)
                tmo_cnt <= tmo_cnt + 1'b1;
            if (state == S_POLL)
                bit_cnt <= '0;
            else if (fall_ev)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // registered outputs
    logic sck_q, valid_q, err_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            sck_q   <= (nxt == S_HIGH);
            valid_q <= (nxt == S_DONE);
            if (accept)
                err_q <= 1'b0;
            else if (state == S_POLL && tick && miso && tmo_hit)
                err_q <= 1'b1;
        end
    end

    assign sck          = sck_q;
    assign mosi         = tx_q[FRAME_BITS-1];
    assign busy         = (state != S_IDLE);
    assign result       = rx_q;
    assign result_valid = valid_q;
    assign timeout_err  = err_q;

    a_r1_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    a_r2_frame_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOW && $past(state) == S_POLL) |-> !$past(miso));
    a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!busy && !sck));
endmodule

// File: tb/sim_adc_frame_reader.sv
`timescale 1ns/1ps
module sim_adc_frame_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_en = 0, cfg_sgl = 0, cfg_odd = 0, cfg_en2 = 0;
    logic        cfg_temp = 0, cfg_rej_a = 0, cfg_rej_b = 0, cfg_spd = 0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  half_div = 8'd1;
    logic [15:0] tmo_limit = '0;
    logic        miso;
    logic        sck, mosi, busy, result_valid, timeout_err;
    logic [31:0] result;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    int cyc = 0;

    // converter model
    logic        ready = 1'b0;
    logic [31:0] dev_word = '0;
    int          dev_idx = 0;
    int          rise_total = 0;
    int          last_rise = 0, prev_rise = 0;
    logic [31:0] cap_cfg = '0;
    logic        hi_mosi = 1'b0;
    bit          mosi_moved_high = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    assign miso = (!ready || dev_idx >= 32) ? 1'b1 : dev_word[31 - dev_idx];

    always @(negedge sck or negedge ready) begin
        if (!ready) dev_idx <= 0;
        else if (dev_idx < 32) dev_idx <= dev_idx + 1;
    end

    always @(posedge sck) begin
        rise_total = rise_total + 1;
        prev_rise  = last_rise;
        last_rise  = cyc;
        cap_cfg    = {cap_cfg[30:0], mosi};
        hi_mosi    = mosi;
    end

    always @(negedge clk) if (sck && mosi !== hi_mosi) mosi_moved_high = 1;

    adc_frame_reader u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_en(cfg_en), .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd), .cfg_addr(cfg_addr),
        .cfg_en2(cfg_en2), .cfg_temp(cfg_temp), .cfg_rej_a(cfg_rej_a),
        .cfg_rej_b(cfg_rej_b), .cfg_spd(cfg_spd),
        .half_div(half_div), .tmo_limit(tmo_limit), .miso(miso),
        .sck(sck), .mosi(mosi), .busy(busy), .result(result),
        .result_valid(result_valid), .timeout_err(timeout_err)
    );

    function automatic logic [31:0] exp_cfg();
        logic [31:0] w = '0;
        w[31] = 1'b1;      w[30] = 1'b0;
        w[29] = cfg_en;    w[28] = cfg_sgl;  w[27] = cfg_odd;
        w[26:24] = cfg_addr;
        w[23] = cfg_en2;   w[22] = cfg_temp; w[21] = cfg_rej_a;
        w[20] = cfg_rej_b; w[19] = cfg_spd;
        return w;
    endfunction

    function automatic int exp_period(input logic [7:0] d);
        return 2 * ((d == 0) ? 1 : int'(d));
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_frame(input logic [31:0] data, input int delay, input bit mid_start);
        int rises0;
        int n;
        logic [31:0] exp_r;
        exp_r = {1'b0, data[30:0]};
        @(negedge clk);
        ready = 1'b0;
        dev_word = exp_r;
        mosi_moved_high = 0;
        rises0 = rise_total;
        pulse_start();
        repeat (delay) @(negedge clk);
        check(rise_total == rises0, "R2 no pulse before ready", rise_total - rises0, 0);
        ready = 1'b1;
        if (mid_start) begin
            repeat (20) @(negedge clk);
            pulse_start();
        end
        n = 0;
        while (!result_valid && n < 5000) begin @(negedge clk); n++; end
        check(result_valid, "R7 strobe seen", result_valid, 1);
        check(result == exp_r, "R4 result word", result, exp_r);
        check(rise_total - rises0 == 32, "R3 pulse count", rise_total - rises0, 32);
        check(cap_cfg == exp_cfg(), "R6 config word", cap_cfg, exp_cfg());
        check(last_rise - prev_rise == exp_period(half_div), "R3 period",
              last_rise - prev_rise, exp_period(half_div));
        check(!mosi_moved_high, "R5 mosi steady while high", mosi_moved_high, 0);
        @(negedge clk);
        check(!result_valid && !busy, "R7 single strobe then idle",
              {result_valid, busy}, 0);
        if (mid_start) begin
            repeat (40) @(negedge clk);
            check(!busy && rise_total - rises0 == 32, "R9 start ignored while busy",
                  rise_total - rises0, 32);
        end
    endtask

    task automatic rand_cfg();
        {cfg_en, cfg_sgl, cfg_odd, cfg_en2, cfg_temp, cfg_rej_a, cfg_rej_b, cfg_spd}
            = 8'($urandom);
        cfg_addr = 3'($urandom);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        check({sck, mosi, busy, result_valid, timeout_err} == 0, "R1 reset state",
              {sck, mosi, busy, result_valid, timeout_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({sck, busy, result_valid, timeout_err} == 0, "R1 after release",
              {sck, busy, result_valid, timeout_err}, 0);

        // directed frames
        tmo_limit = 16'd0;
        half_div = 8'd1; cfg_addr = 3'd5; cfg_en = 1; cfg_spd = 1;
        run_frame(32'h7FFF_FFFF, 10, 0);
        half_div = 8'd0; rand_cfg();
        run_frame(32'h0000_0001, 3, 0);
        half_div = 8'd3; rand_cfg();
        run_frame(32'h5A5A_C33C, 30, 1);

        // random frames
        tmo_limit = 16'd1000;
        for (int i = 0; i < 12; i++) begin
            half_div = 8'($urandom_range(4, 0));
            rand_cfg();
            run_frame($urandom, int'($urandom_range(40, 0)), 0);
        end

        // timeout: R8
        begin
            int n;
            int rises0;
            @(negedge clk);
            ready = 1'b0;
            half_div = 8'd2; tmo_limit = 16'd5;
            rises0 = rise_total;
            pulse_start();
            repeat (7) @(negedge clk);
            check(!timeout_err && busy, "R8 no early timeout", timeout_err, 0);
            n = 0;
            while (!timeout_err && n < 20) begin @(negedge clk); n++; end
            check(timeout_err, "R8 timeout raised", timeout_err, 1);
            check(!busy && rise_total == rises0, "R8 no pulses on timeout",
                  rise_total - rises0, 0);
            tmo_limit = 16'd1000;
            run_frame(32'h1234_5678, 4, 0);
            check(!timeout_err, "R8 cleared by start", timeout_err, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule